// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Controller

This block gathers a parameterised set of level-sensitive interrupt lines (128 by default) and turns them into a single interrupt request to a processor. Each line has a mask bit and a software-force bit. Both are kept in 32-bit banks. Software changes them only through per-bank write-one-to-set and write-one-to-clear registers, so it never has to read, modify and write a bank. A line counts as pending when its input or its software-force bit is high and its mask bit is low.

When no decision is held, the controller latches the lowest-numbered pending line and raises the request. The latched number is reported through a sorted-interrupt register. The number and the request stay frozen until software writes end-of-interrupt; arbitration then resumes. A read of the sorted register is flagged spurious, with the upper bits all ones, in three cases:
- nothing is held;
- the held line has since been masked;
- the held line has since dropped.

A soft reset masks every line, clears the software bits and releases the held decision. It then runs for a fixed number of cycles before its done flag returns.

The block sits on a plain 32-bit register port. Writes take effect at the clock edge. Reads are combinational from the address.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After hardware reset, all mask bits are 1, all software-force bits are 0, `irqReq` is 0, the status register (0x14) bit 0 reads 1, and the sorted register (0x40) reads 0xFFFFFF80.
- R2: For bank b (line number >> 5 selects the bank, line & 31 selects the bit), a write to 0x88 + 0x20*b clears mask bits where the data is 1, and a write to 0x8C + 0x20*b sets mask bits where the data is 1. Zero data bits leave their lines unchanged. Both offsets read back the bank's mask. A masked line never causes a request.
- R3: A write to 0x90 + 0x20*b sets software-force bits where the data is 1, and a write to 0x94 + 0x20*b clears them. Both offsets read back the bank's force bits. A force bit acts exactly like its input line being high.
- R4: When no decision is held, no soft reset is in progress and some line is pending at a clock edge, the lowest pending line number is latched at that edge and `irqReq` is 1 from then on.
- R5: Reading 0x40 returns the held line number in bits 6:0 with bits 31:7 zero while that line is still pending. Otherwise it returns 0xFFFFFF80.
- R6: While a decision is held, the number and `irqReq` do not change until a write to 0x48 with bit 0 set. That write releases the decision at its edge, and a new decision may be latched at the next edge. A write to 0x48 with bit 0 clear has no effect.
- R7: A write to 0x10 with bit 1 set masks all lines, clears all force bits and releases any held decision at its edge. Status bit 0 then reads 0 for exactly 4 cycles before returning to 1, and no decision is latched during those cycles.
- R8: Offset 0x00 reads the revision parameter, and offset 0x68 always reads 0xFF, whatever is written to it. Writes to any unmapped offset change no state, and reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | 128 | Level-sensitive interrupt lines |
| busSel | input | 1 | Register access select |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | 8 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr` |
| irqReq | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the controller with its default parameters: 128 lines in four 32-bit banks, a soft reset of 4 cycles, and revision 0x21. This reaches both directions of every bank boundary, including the winner between lines 31 and 32 and the topmost line 127 in the last bank.

The default soft-reset length makes the whole busy window observable cycle by cycle. With it, the bench can check that an unmask written during the window has its effect only once the window ends.

// File: rtl/banked_irq_pkg.sv
package banked_irq_pkg;

  typedef struct packed {
    logic softRst;  // restore masks, drop force bits, release decision
    logic eoi;      // end-of-interrupt accepted this cycle
  } ctrlStrobe_t;

  localparam int OFF_REVISION = 'h00;
  localparam int OFF_SYSCFG   = 'h10;
  localparam int OFF_STATUS   = 'h14;
  localparam int OFF_SORTED   = 'h40;
  localparam int OFF_CONTROL  = 'h48;
  localparam int OFF_THRESH   = 'h68;
  localparam int BANK_BASE    = 'h88;
  localparam int BANK_STRIDE  = 'h20;

  // register slots inside one bank
  localparam int SLOT_MASK_CLR = 0;
  localparam int SLOT_MASK_SET = 4;
  localparam int SLOT_FORCE_SET = 8;
  localparam int SLOT_FORCE_CLR = 12;

endpackage

// File: rtl/irq_datapath.sv
module irq_datapath
  import banked_irq_pkg::*;
#(
  parameter int NUM_LINES = 128,
  parameter int BANK_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int ID_W      = $clog2(NUM_LINES),
  parameter logic [31:0] REVISION = 32'h0000_0021
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqIn,
  input  logic                 busSel,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [DATA_W-1:0]    busWdata,
  input  ctrlStrobe_t          strobe,
  input  logic                 held,
  input  logic [ID_W-1:0]      heldId,
  input  logic                 busy,
  output logic [DATA_W-1:0]    busRdata,
  output logic                 pendAny,
  output logic [ID_W-1:0]      winnerId
);

  localparam int NUM_BANKS = NUM_LINES / BANK_W;
  localparam logic [DATA_W-1:0] SPURIOUS = {{(DATA_W-ID_W){1'b1}}, {ID_W{1'b0}}};

  logic [NUM_LINES-1:0] maskBits;
  logic [NUM_LINES-1:0] swBits;
  logic [NUM_LINES-1:0] pending;
  logic [NUM_BANKS-1:0] hitMClr, hitMSet, hitSSet, hitSClr;
  logic                 wrEn;

  assign wrEn    = busSel && busWrite;
  assign pending = (irqIn | swBits) & ~maskBits;
  assign pendAny = |pending;

  // per-bank address decode for the four write-one registers
  for (genvar b = 0; b < NUM_BANKS; b++) begin : gDecode
    localparam int BASE = BANK_BASE + b * BANK_STRIDE;
    assign hitMClr[b] = wrEn && (busAddr == ADDR_W'(BASE + SLOT_MASK_CLR));
    assign hitMSet[b] = wrEn && (busAddr == ADDR_W'(BASE + SLOT_MASK_SET));
    assign hitSSet[b] = wrEn && (busAddr == ADDR_W'(BASE + SLOT_FORCE_SET));
    assign hitSClr[b] = wrEn && (busAddr == ADDR_W'(BASE + SLOT_FORCE_CLR));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskBits <= '1;
      swBits   <= '0;
    end else if (strobe.softRst) begin
      maskBits <= '1;
      swBits   <= '0;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (hitMClr[b]) maskBits[b*BANK_W +: BANK_W] <= maskBits[b*BANK_W +: BANK_W] & ~busWdata[BANK_W-1:0];
        if (hitMSet[b]) maskBits[b*BANK_W +: BANK_W] <= maskBits[b*BANK_W +: BANK_W] | busWdata[BANK_W-1:0];
        if (hitSSet[b]) swBits[b*BANK_W +: BANK_W]   <= swBits[b*BANK_W +: BANK_W] | busWdata[BANK_W-1:0];
        if (hitSClr[b]) swBits[b*BANK_W +: BANK_W]   <= swBits[b*BANK_W +: BANK_W] & ~busWdata[BANK_W-1:0];
      end
    end
  end

  // lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    winnerId = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (pending[i]) winnerId = ID_W'(i);
    end
  end

  always_comb begin
    busRdata = '0;
    if (busAddr == ADDR_W'(OFF_REVISION)) begin
      busRdata = REVISION;
    end else if (busAddr == ADDR_W'(OFF_STATUS)) begin
      busRdata = DATA_W'(!busy);
    end else if (busAddr == ADDR_W'(OFF_SORTED)) begin
      busRdata = (held && pending[heldId]) ? DATA_W'(heldId) : SPURIOUS;
    end else if (busAddr == ADDR_W'(OFF_THRESH)) begin
      busRdata = DATA_W'(8'hFF);
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (busAddr == ADDR_W'(BANK_BASE + b*BANK_STRIDE + SLOT_MASK_CLR) ||
            busAddr == ADDR_W'(BANK_BASE + b*BANK_STRIDE + SLOT_MASK_SET))
          busRdata = DATA_W'(maskBits[b*BANK_W +: BANK_W]);
        if (busAddr == ADDR_W'(BANK_BASE + b*BANK_STRIDE + SLOT_FORCE_SET) ||
            busAddr == ADDR_W'(BANK_BASE + b*BANK_STRIDE + SLOT_FORCE_CLR))
          busRdata = DATA_W'(swBits[b*BANK_W +: BANK_W]);
      end
    end
  end

  logic [NUM_LINES-1:0] belowWinner;
  assign belowWinner = (NUM_LINES'(1) << winnerId) - NUM_LINES'(1);

  AST_WINNER_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    pendAny |-> pending[winnerId]); // R4
  AST_WINNER_LOWEST: assert property (@(posedge clk) disable iff (!rstN)
    pendAny |-> ((pending & belowWinner) == '0)); // R4
  AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.softRst |=> ((&maskBits) && !(|swBits))); // R7
  AST_EOI_KEEPS_MASKS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.eoi && !strobe.softRst) |=> ($stable(maskBits) && $stable(swBits))); // R6

endmodule

// File: rtl/irq_control.sv
module irq_control
  import banked_irq_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int ID_W       = 7,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        ctlWdata,
  input  logic              pendAny,
  input  logic [ID_W-1:0]   winnerId,
  output ctrlStrobe_t       strobe,
  output logic              held,
  output logic [ID_W-1:0]   heldId,
  output logic              busy,
  output logic              irqReq
);

  localparam int CNT_W = $clog2(RST_CYCLES + 1);

  logic             wrEn;
  logic [CNT_W-1:0] rstCnt;

  assign wrEn           = busSel && busWrite;
  assign strobe.softRst = wrEn && (busAddr == ADDR_W'(OFF_SYSCFG)) && ctlWdata[1];
  assign strobe.eoi     = wrEn && (busAddr == ADDR_W'(OFF_CONTROL)) && ctlWdata[0];
  assign busy           = (rstCnt != '0);
  assign irqReq         = held;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      held   <= 1'b0;
      heldId <= '0;
      rstCnt <= '0;
    end else if (strobe.softRst) begin
      held   <= 1'b0;
      rstCnt <= CNT_W'(RST_CYCLES);
    end else begin
      if (busy) rstCnt <= rstCnt - 1'b1;
      if (held) begin
        if (strobe.eoi) held <= 1'b0;
      end else if (pendAny && !busy) begin
        held   <= 1'b1;
        heldId <= winnerId;
      end
    end
  end

  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (held && !strobe.eoi && !strobe.softRst) |=> (held && $stable(heldId))); // R6
  AST_EOI_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    (held && strobe.eoi && !strobe.softRst) |=> !held); // R6
  AST_SRST_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.softRst |=> (busy && !held)); // R7
  AST_NO_CAPTURE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !held) |=> !held); // R7

endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
  import banked_irq_pkg::*;
#(
  parameter int NUM_LINES  = 128,
  parameter int BANK_W     = 32,
  parameter int ADDR_W     = 8,
  parameter int RST_CYCLES = 4,
  parameter logic [31:0] REVISION = 32'h0000_0021
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqIn,
  input  logic                 busSel,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  output logic                 irqReq
);

  localparam int ID_W = $clog2(NUM_LINES);

  ctrlStrobe_t     strobe;
  logic            held;
  logic [ID_W-1:0] heldId;
  logic            busy;
  logic            pendAny;
  logic [ID_W-1:0] winnerId;

  irq_control #(
    .ADDR_W(ADDR_W), .ID_W(ID_W), .RST_CYCLES(RST_CYCLES)
  ) u_control (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .ctlWdata(busWdata[1:0]), .pendAny(pendAny),
    .winnerId(winnerId), .strobe(strobe), .held(held), .heldId(heldId),
    .busy(busy), .irqReq(irqReq)
  );

  irq_datapath #(
    .NUM_LINES(NUM_LINES), .BANK_W(BANK_W), .ADDR_W(ADDR_W), .DATA_W(32),
    .ID_W(ID_W), .REVISION(REVISION)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .busSel(busSel),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .strobe(strobe), .held(held), .heldId(heldId), .busy(busy),
    .busRdata(busRdata), .pendAny(pendAny), .winnerId(winnerId)
  );

endmodule

// File: tb/banked_irq_ctrl_bench.sv
module banked_irq_ctrl_bench;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [127:0] irqIn = '0;
  logic         busSel = 1'b0;
  logic         busWrite = 1'b0;
  logic [7:0]   busAddr = '0;
  logic [31:0]  busWdata = '0;
  logic [31:0]  busRdata;
  logic         irqReq;

  int nRun = 0;
  int nFail = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  banked_irq_ctrl #(.REVISION(32'h0000_0021)) u_banked_irq_ctrl (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .busSel(busSel),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .irqReq(irqReq)
  );

  // ---------------- behavioural reference model ----------------
  bit [127:0] mM;
  bit [127:0] sM;
  bit         heldM;
  int         idM;
  int         cntM;

  function automatic bit [127:0] pendM();
    return (irqIn | sM) & ~mM;
  endfunction

  function automatic int lowestOf(input bit [127:0] p);
    for (int i = 0; i < 128; i++) if (p[i]) return i;
    return -1;
  endfunction

  function automatic logic [31:0] modelRead(input logic [7:0] a);
    bit [127:0] p;
    p = pendM();
    if (a == 8'h00) return 32'h21;
    if (a == 8'h14) return (cntM == 0) ? 32'd1 : 32'd0;
    if (a == 8'h40) return (heldM && p[idM]) ? 32'(idM) : 32'hFFFF_FF80;
    if (a == 8'h68) return 32'hFF;
    for (int b = 0; b < 4; b++) begin
      int base;
      base = 'h88 + b * 'h20;
      if (a == 8'(base) || a == 8'(base + 4)) return mM[b*32 +: 32];
      if (a == 8'(base + 8) || a == 8'(base + 12)) return sM[b*32 +: 32];
    end
    return 32'h0;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mM = '1; sM = '0; heldM = 0; idM = 0; cntM = 0;
    end else begin
      bit [127:0] p;
      bit wr;
      int cntOld;
      p = pendM();
      wr = busSel && busWrite;
      cntOld = cntM;
      if (wr && busAddr == 8'h10 && busWdata[1]) begin
        mM = '1; sM = '0; heldM = 0; cntM = 4;
      end else begin
        if (wr) begin
          for (int b = 0; b < 4; b++) begin
            int base;
            base = 'h88 + b * 'h20;
            if (busAddr == 8'(base))      mM[b*32 +: 32] = mM[b*32 +: 32] & ~busWdata;
            if (busAddr == 8'(base + 4))  mM[b*32 +: 32] = mM[b*32 +: 32] | busWdata;
            if (busAddr == 8'(base + 8))  sM[b*32 +: 32] = sM[b*32 +: 32] | busWdata;
            if (busAddr == 8'(base + 12)) sM[b*32 +: 32] = sM[b*32 +: 32] & ~busWdata;
          end
        end
        if (cntM > 0) cntM = cntM - 1;
        if (heldM) begin
          if (wr && busAddr == 8'h48 && busWdata[0]) heldM = 0;
        end else if (cntOld == 0 && p != '0) begin
          heldM = 1;
          idM = lowestOf(p);
        end
      end
    end
  end

  // ---------------- checking ----------------
  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // request compared with the model on every clock (R4, R6)
  always @(negedge clk) begin
    if (rstN && !finished)
      check(irqReq == heldM, "R4/R6 irqReq per cycle", 32'(irqReq), 32'(heldM));
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWrite = 0; busWdata = '0;
  endtask

  task automatic rdChk(input logic [7:0] a, input string tag);
    logic [31:0] exp;
    @(negedge clk);
    busSel = 1; busWrite = 0; busAddr = a;
    #1;
    exp = modelRead(a);
    check(busRdata === exp, tag, busRdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setLine(input int n, input bit v);
    @(negedge clk);
    irqIn[n] = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1;
    // R1: reset state
    rdChk(8'h14, "R1 status done");
    rdChk(8'h40, "R1 sorted spurious");
    for (int b = 0; b < 4; b++) rdChk(8'('h88 + b*'h20), "R1 masks all set");
    for (int b = 0; b < 4; b++) rdChk(8'('h90 + b*'h20), "R1 force bits clear");
    rdChk(8'h00, "R8 revision");
    rdChk(8'h68, "R8 threshold");

    // R2: masked lines cause nothing
    @(negedge clk); irqIn = '1;
    idle(3);
    rdChk(8'h40, "R2 masked lines ignored");
    @(negedge clk); irqIn = '0;

    // R2: unmask lines 5 and 40
    wr(8'h88, 32'h0000_0020);
    wr(8'hA8, 32'h0000_0100);
    rdChk(8'h88, "R2 bank0 mask");
    rdChk(8'hAC, "R2 bank1 mask via set offset");
    rdChk(8'hC8, "R2 bank2 untouched");

    // R4: lowest pending wins
    @(negedge clk); irqIn[40] = 1; irqIn[70] = 1; irqIn[5] = 1;
    idle(2);
    rdChk(8'h40, "R4 lowest line 5");

    // R6: eoi with bit0 clear ignored, then real eoi
    wr(8'h48, 32'h0000_0002);
    idle(2);
    rdChk(8'h40, "R6 eoi bit0 clear ignored");
    wr(8'h48, 32'h1);
    idle(2);
    rdChk(8'h40, "R6 rearbitrate same line");

    // R5: held line drops
    setLine(5, 0);
    rdChk(8'h40, "R5 dropped line spurious");
    wr(8'h48, 32'h1);
    idle(2);
    rdChk(8'h40, "R4 next winner 40");

    // R5: held line masked
    wr(8'hAC, 32'h0000_0100);
    rdChk(8'h40, "R5 masked line spurious");
    wr(8'h48, 32'h1);
    idle(2);
    rdChk(8'h40, "R6 nothing pending after eoi");

    // R3: software force on line 70
    setLine(70, 0);
    setLine(40, 0);
    wr(8'hC8, 32'h0000_0040);
    idle(2);
    rdChk(8'h40, "R3 no request before force");
    wr(8'hD0, 32'h0000_0040);
    idle(2);
    rdChk(8'h40, "R3 forced line 70");
    rdChk(8'hD4, "R3 force readback");
    wr(8'hD4, 32'h0000_0040);
    rdChk(8'h40, "R3 force cleared spurious");
    wr(8'h48, 32'h1);
    idle(2);

    // R4: bank boundary 31 vs 32
    wr(8'h88, 32'h8000_0000);
    wr(8'hA8, 32'h0000_0001);
    @(negedge clk); irqIn[32] = 1; irqIn[31] = 1;
    idle(2);
    rdChk(8'h40, "R4 line 31 beats 32");
    setLine(31, 0);
    wr(8'h48, 32'h1);
    idle(2);
    rdChk(8'h40, "R4 line 32 next");
    setLine(32, 0);
    wr(8'h48, 32'h1);
    idle(2);

    // R8: unmapped and threshold writes
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h84, 32'hFFFF_FFFF);
    wr(8'h68, 32'h0000_0012);
    rdChk(8'h20, "R8 unmapped read zero");
    rdChk(8'h84, "R8 unmapped read zero");
    rdChk(8'h44, "R8 unmapped read zero");
    rdChk(8'h68, "R8 threshold fixed");
    rdChk(8'h88, "R8 masks unchanged");
    rdChk(8'h90, "R8 force unchanged");

    // R7: soft reset with a held decision and a force bit
    wr(8'hE8, 32'h8000_0000);
    wr(8'hF0, 32'h0000_0001);
    setLine(127, 1);
    idle(2);
    rdChk(8'h40, "R7 line 127 held before reset");
    wr(8'h10, 32'h0000_0002);
    rdChk(8'h14, "R7 status busy");
    wr(8'hE8, 32'h8000_0000);
    for (int k = 0; k < 5; k++) rdChk(8'h14, "R7 status countdown");
    rdChk(8'hF0, "R7 force cleared");
    rdChk(8'h88, "R7 bank0 masked");
    idle(2);
    rdChk(8'h40, "R7 capture after busy");
    wr(8'h48, 32'h1);
    idle(3);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule